// File: doc/BRIEF.md
# Arbiter Request-Disable Control Register

This block sits between the external bus-master request pins and the bus arbiters. It holds an 8-bit control register in I/O space at a fixed address. Bit 0 of that register stops new external requests from reaching the arbiters. The other seven bits are reserved. The register answers an I/O access only when an enable bit in a separate power-management control word is set. When that bit is clear, an access to the same address is not claimed and is flagged for forwarding downstream instead.

While bit 0 is set, the outputs for the external request lines, the graphics-port request lines and the bridge hold request drive the deasserted (high) level. Internal requests pass through unchanged. A request that is already asserted when masking begins is let through until it deasserts, so that the cycle in progress finishes normally. The hold master may be in passive-release mode when bit 0 is set. In that case masking of the hold request is postponed: a pending flag is raised, and masking takes effect only after hold-acknowledge asserts, which marks an active release. This prevents a deadlock. Clearing bit 0 drops the pending flag and removes all masking at the next clock edge.

Top module: `arb_gate_top`

## Requirements
- R1: After reset the register reads 0x00, the pending flag is clear, and every gated request output equals its input.
- R2: A read or write is claimed (io_claim=1, io_forward=0) only when io_addr equals 0x0022 and bit 6 of pm_ctl is 1. A claimed read returns the register on io_rdata. In every other case io_rdata is 0x00.
- R3: An access to 0x0022 while pm_ctl bit 6 is 0 gives io_forward=1 and io_claim=0, and leaves the register unchanged. An access to any other address gives neither io_claim nor io_forward.
- R4: Register bits 7:1 always read 0, and writes to them are ignored. Only bit 0 is stored, from io_wdata bit 0.
- R5: From the cycle after bit 0 is written to 1, a newly asserted request on ext_req_n or agp_req_n appears as high (1) on the gated output. A request is newly asserted when it was high in the previous cycle.
- R6: With bit 0 set and passive_rel=0 at the time of setting, a newly asserted hold_req_n appears as high on hold_req_gated_n.
- R7: int_req_gated_n always equals int_req_n, whatever the register holds.
- R8: If passive_rel=1 when bit 0 goes from 0 to 1 and hold_ack_n is high, hold requests pass unmasked until hold_ack_n is seen low. From the next cycle on, a newly asserted hold request is masked.
- R9: Writing bit 0 to 0 while masking is still deferred cancels the deferral. No hold masking follows until bit 0 is set again.
- R10: A request line that is low when masking begins keeps passing while it stays low. Once it has gone high, a later assertion is masked.
- R11: Writing bit 0 to 0 makes every gated output equal its input from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | I/O access address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| pm_ctl | input | 8 | Power-management control word; bit PM_EN_BIT enables the register |
| io_rdata | output | 8 | Read data for a claimed read, else 0 |
| io_claim | output | 1 | Access decoded by this register |
| io_forward | output | 1 | Access to the address while disabled; to be forwarded |
| ext_req_n | input | N_EXT | External bus-master requests, active low |
| agp_req_n | input | N_AGP | Graphics-port requests, active low |
| hold_req_n | input | 1 | Bridge hold request, active low |
| hold_ack_n | input | 1 | Hold acknowledge, active low |
| passive_rel | input | 1 | Hold master is in passive-release mode |
| int_req_n | input | N_INT | Internal requests, active low |
| ext_req_gated_n | output | N_EXT | External requests toward the arbiter |
| agp_req_gated_n | output | N_AGP | Graphics-port requests toward the arbiter |
| hold_req_gated_n | output | 1 | Hold request toward the arbiter |
| int_req_gated_n | output | N_INT | Internal requests toward the arbiter |

## Verification
The bench builds the block with N_EXT=4, N_AGP=2 and N_INT=2, keeping the 16-bit address and the default register address. These widths are small enough that every external request pattern (16), every graphics-port pattern (4) and every internal pattern (4) is swept both with masking on and with it off. All 256 write data values are written and read back. Every combination of the enable bit and the strobes is driven against the register address and against its neighbours. Directed sequences then cover passive-release deferral and its cancellation, a request that is held through the start of masking, and the release of masking.

// File: rtl/arb_gate_pkg.sv
// Package: shared constants for the arbiter request-disable block.
// Assumes an 8-bit register whose bit 0 is the only implemented field.
package arb_gate_pkg;
    localparam int REG_W       = 8;
    localparam int DIS_BIT     = 0;
    localparam logic [REG_W-1:0] REG_RESET = '0;
endpackage

// File: rtl/arb_io_decode.sv
// Module: arb_io_decode
// Decodes one fixed I/O address. The access is claimed when the enable bit
// of the power-management word is set, otherwise flagged for forwarding.
// Assumes io_rd and io_wr are single-cycle strobes, never both high.
module arb_io_decode #(
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IO_ADDR = 16'h0022,
    parameter int PM_EN_BIT = 6
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        pm_ctl,
    output logic              claim,
    output logic              forward,
    output logic              wr_en
);
    logic hit;

    // Address match for any strobe, then split by the enable bit.
    always_comb begin
        hit     = (io_rd || io_wr) && (io_addr == IO_ADDR);
        claim   = hit && pm_ctl[PM_EN_BIT];
        forward = hit && !pm_ctl[PM_EN_BIT];
        wr_en   = claim && io_wr;
    end
endmodule

// File: rtl/arb_ctl_reg.sv
// Module: arb_ctl_reg
// Holds the disable bit and the passive-release pending flag.
// Pending is raised when the bit goes 0->1 with passive release active and
// no acknowledge seen. It drops on acknowledge or when the bit is cleared.
module arb_ctl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic passive_rel,
    input  logic hold_ack_n,
    output logic dis_q,
    output logic pend_q
);
    logic dis_d;
    logic pend_d;
    logic set_edge;

    // Next-state for the disable bit and the deferral flag.
    always_comb begin
        set_edge = wr_en && wr_bit && !dis_q;
        dis_d    = wr_en ? wr_bit : dis_q;
        pend_d   = dis_d && hold_ack_n && (set_edge ? passive_rel : pend_q);
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            dis_q  <= dis_d;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/arb_req_gate.sv
// Module: arb_req_gate
// Masks active-low request lines while mask_on is high. A line that was
// already asserted before masking began keeps passing until it deasserts.
module arb_req_gate #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_on,
    input  logic [N-1:0] req_n,
    output logic [N-1:0] gated_n
);
    logic [N-1:0] keep_q;
    logic [N-1:0] keep_d;

    // Per-line grandfathering and output masking.
    always_comb begin
        keep_d  = ~req_n & (~{N{mask_on}} | keep_q);
        gated_n = req_n | ({N{mask_on}} & ~keep_q);
    end

    // Grandfather flags, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) keep_q <= '0;
        else        keep_q <= keep_d;
    end
endmodule

// File: rtl/arb_gate_top.sv
// Module: arb_gate_top
// I/O control register with request masking ahead of the bus arbiters.
// Assumes request pins already synchronised to clk.
module arb_gate_top #(
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IO_ADDR = 16'h0022,
    parameter int PM_EN_BIT = 6,
    parameter int N_EXT     = 5,
    parameter int N_AGP     = 1,
    parameter int N_INT     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    input  logic [7:0]        pm_ctl,
    output logic [7:0]        io_rdata,
    output logic              io_claim,
    output logic              io_forward,
    input  logic [N_EXT-1:0]  ext_req_n,
    input  logic [N_AGP-1:0]  agp_req_n,
    input  logic              hold_req_n,
    input  logic              hold_ack_n,
    input  logic              passive_rel,
    input  logic [N_INT-1:0]  int_req_n,
    output logic [N_EXT-1:0]  ext_req_gated_n,
    output logic [N_AGP-1:0]  agp_req_gated_n,
    output logic              hold_req_gated_n,
    output logic [N_INT-1:0]  int_req_gated_n
);
    import arb_gate_pkg::*;

    logic wr_en;
    logic dis_q;
    logic pend_q;
    logic hold_mask;

    arb_io_decode #(.ADDR_W(ADDR_W), .IO_ADDR(IO_ADDR), .PM_EN_BIT(PM_EN_BIT)) dec_i (
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .pm_ctl(pm_ctl),
        .claim(io_claim), .forward(io_forward), .wr_en(wr_en)
    );

    arb_ctl_reg ctl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(io_wdata[DIS_BIT]),
        .passive_rel(passive_rel), .hold_ack_n(hold_ack_n),
        .dis_q(dis_q), .pend_q(pend_q)
    );

    // Read-back: reserved bits are zero, data only on a claimed read.
    always_comb begin
        io_rdata = REG_RESET;
        if (io_claim && io_rd) io_rdata[DIS_BIT] = dis_q;
    end

    // Hold masking waits for the passive-release deferral to end.
    always_comb hold_mask = dis_q && !pend_q;

    arb_req_gate #(.N(N_EXT)) ext_gate_i (
        .clk(clk), .rst_n(rst_n), .mask_on(dis_q),
        .req_n(ext_req_n), .gated_n(ext_req_gated_n)
    );

    arb_req_gate #(.N(N_AGP)) agp_gate_i (
        .clk(clk), .rst_n(rst_n), .mask_on(dis_q),
        .req_n(agp_req_n), .gated_n(agp_req_gated_n)
    );

    arb_req_gate #(.N(1)) hold_gate_i (
        .clk(clk), .rst_n(rst_n), .mask_on(hold_mask),
        .req_n(hold_req_n), .gated_n(hold_req_gated_n)
    );

    // Internal requests are never masked.
    always_comb int_req_gated_n = int_req_n;
endmodule

// File: rtl/arb_gate_chk.sv
// Module: arb_gate_chk
// Assertion checker bound to arb_gate_top.
module arb_gate_chk #(
    parameter int N_EXT = 5,
    parameter int N_AGP = 1,
    parameter int N_INT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_claim,
    input logic             io_forward,
    input logic             io_wr,
    input logic [7:0]       io_rdata,
    input logic             dis_q,
    input logic             pend_q,
    input logic [N_EXT-1:0] ext_req_n,
    input logic [N_EXT-1:0] ext_req_gated_n,
    input logic [N_AGP-1:0] agp_req_n,
    input logic [N_AGP-1:0] agp_req_gated_n,
    input logic             hold_req_n,
    input logic             hold_req_gated_n,
    input logic [N_INT-1:0] int_req_n,
    input logic [N_INT-1:0] int_req_gated_n
);
    a_r2_claim_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_claim && io_forward));
    a_r3_forward_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (io_forward && io_wr) |=> (dis_q == $past(dis_q)));
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[7:1] == 7'd0);
    a_r5_ext_new_masked: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |-> ((~ext_req_gated_n & $past(ext_req_n)) == '0));
    a_r5_agp_new_masked: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |-> ((~agp_req_gated_n & $past(agp_req_n)) == '0));
    a_r6_hold_new_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && !pend_q) |-> !(!hold_req_gated_n && $past(hold_req_n)));
    a_r7_int_pass: assert property (@(posedge clk) disable iff (!rst_n)
        int_req_gated_n == int_req_n);
    a_r8_pending_pass: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (hold_req_gated_n == hold_req_n));
    a_r9_pend_needs_dis: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> dis_q);
    a_r11_clear_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_q |-> (ext_req_gated_n == ext_req_n && agp_req_gated_n == agp_req_n
                    && hold_req_gated_n == hold_req_n));
endmodule

bind arb_gate_top arb_gate_chk #(.N_EXT(N_EXT), .N_AGP(N_AGP), .N_INT(N_INT)) chk_i (
    .clk(clk), .rst_n(rst_n), .io_claim(io_claim), .io_forward(io_forward),
    .io_wr(io_wr), .io_rdata(io_rdata), .dis_q(dis_q), .pend_q(pend_q),
    .ext_req_n(ext_req_n), .ext_req_gated_n(ext_req_gated_n),
    .agp_req_n(agp_req_n), .agp_req_gated_n(agp_req_gated_n),
    .hold_req_n(hold_req_n), .hold_req_gated_n(hold_req_gated_n),
    .int_req_n(int_req_n), .int_req_gated_n(int_req_gated_n)
);

// File: tb/arb_gate_top_tb_top.sv
// Bench: sweeps register access and request patterns on a small build.
module arb_gate_top_tb_top;
    localparam int NE = 4;
    localparam int NA = 2;
    localparam int NI = 2;
    localparam logic [15:0] RADDR = 16'h0022;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] io_wdata = '0, pm_ctl = 8'h40;
    logic [7:0] io_rdata;
    logic io_claim, io_forward;
    logic [NE-1:0] ext_req_n = '1;
    logic [NA-1:0] agp_req_n = '1;
    logic hold_req_n = 1'b1, hold_ack_n = 1'b1, passive_rel = 1'b0;
    logic [NI-1:0] int_req_n = '1;
    logic [NE-1:0] ext_g;
    logic [NA-1:0] agp_g;
    logic hold_g;
    logic [NI-1:0] int_g;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    arb_gate_top #(.N_EXT(NE), .N_AGP(NA), .N_INT(NI)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .pm_ctl(pm_ctl), .io_rdata(io_rdata),
        .io_claim(io_claim), .io_forward(io_forward), .ext_req_n(ext_req_n),
        .agp_req_n(agp_req_n), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n),
        .passive_rel(passive_rel), .int_req_n(int_req_n),
        .ext_req_gated_n(ext_g), .agp_req_gated_n(agp_g),
        .hold_req_gated_n(hold_g), .int_req_gated_n(int_g)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge (inputs change here, outputs settle).
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        tick();
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d,
                           output logic c, output logic f);
        io_addr = a; io_rd = 1'b1;
        #1;
        d = io_rdata; c = io_claim; f = io_forward;
        tick();
        io_rd = 1'b0;
    endtask

    task automatic idle_reqs();
        ext_req_n = '1; agp_req_n = '1; hold_req_n = 1'b1; int_req_n = '1;
        tick();
    endtask

    logic [7:0] rd;
    logic cl, fw;

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        io_read(RADDR, rd, cl, fw);
        chk("R1 reset value", rd, 8'h00);
        ext_req_n = 4'b0101; agp_req_n = 2'b10; hold_req_n = 1'b0;
        #1;
        chk("R1 ext pass", ext_g, 4'b0101);
        chk("R1 agp pass", agp_g, 2'b10);
        chk("R1 hold pass", hold_g, 1'b0);
        idle_reqs();

        // R4: all data values; only bit 0 stored
        for (int d = 0; d < 256; d++) begin
            io_write(RADDR, d[7:0]);
            io_read(RADDR, rd, cl, fw);
            chk("R4 readback", rd, {7'd0, d[0]});
        end
        io_write(RADDR, 8'h00);

        // R2/R3: decode sweep over enable bit, strobe and address
        for (int en = 0; en < 2; en++) begin
            for (int ai = 0; ai < 4; ai++) begin
                logic [15:0] a;
                logic hitx;
                a = (ai == 0) ? RADDR : (ai == 1) ? 16'h0023 :
                    (ai == 2) ? 16'h0021 : 16'h1022;
                hitx = (ai == 0);
                pm_ctl = en[0] ? 8'h40 : 8'hBF;
                io_write(RADDR, 8'h00);
                pm_ctl = en[0] ? 8'h40 : 8'hBF;
                io_read(a, rd, cl, fw);
                chk("R2 claim", cl, hitx && en[0]);
                chk("R3 forward", fw, hitx && !en[0]);
                chk("R2 rdata", rd, 8'h00);
                io_write(a, 8'hFF);
                pm_ctl = 8'h40;
                io_read(RADDR, rd, cl, fw);
                chk("R3 write effect", rd, {7'd0, hitx && en[0]});
            end
        end
        pm_ctl = 8'h40;
        io_write(RADDR, 8'h00);
        idle_reqs();

        // R5/R7/R11: exhaustive request patterns, masking on and off
        for (int m = 0; m < 2; m++) begin
            passive_rel = 1'b0;
            io_write(RADDR, {7'd0, m[0]});
            for (int p = 0; p < 16; p++) begin
                idle_reqs();
                ext_req_n = p[3:0]; agp_req_n = p[1:0]; int_req_n = p[3:2];
                hold_req_n = p[0];
                #1;
                chk(m ? "R5 ext masked" : "R11 ext pass", ext_g, m ? 4'hF : p[3:0]);
                chk(m ? "R5 agp masked" : "R11 agp pass", agp_g, m ? 2'b11 : p[1:0]);
                chk(m ? "R6 hold masked" : "R11 hold pass", hold_g, m ? 1'b1 : p[0]);
                chk("R7 int pass", int_g, p[3:2]);
            end
            idle_reqs();
        end

        // R11: stuck-low requests pass right after clearing
        ext_req_n = 4'b0000; agp_req_n = 2'b00; hold_req_n = 1'b0;
        tick();
        chk("R11 masked before clear", ext_g, 4'hF);
        io_write(RADDR, 8'h00);
        chk("R11 ext after clear", ext_g, 4'h0);
        chk("R11 agp after clear", agp_g, 2'b00);
        chk("R11 hold after clear", hold_g, 1'b0);
        idle_reqs();

        // R10: request asserted before masking keeps passing
        ext_req_n = 4'b1010; tick();
        io_write(RADDR, 8'h01);
        chk("R10 held request passes", ext_g, 4'b1010);
        tick();
        chk("R10 still passes", ext_g, 4'b1010);
        ext_req_n = 4'b1111; tick();
        ext_req_n = 4'b1010; #1;
        chk("R10 reassert masked", ext_g, 4'b1111);
        io_write(RADDR, 8'h00);
        idle_reqs();

        // R8: passive-release deferral, ended by hold acknowledge
        passive_rel = 1'b1;
        io_write(RADDR, 8'h01);
        hold_req_n = 1'b0; #1;
        chk("R8 pending passes", hold_g, 1'b0);
        tick();
        chk("R8 pending still passes", hold_g, 1'b0);
        hold_req_n = 1'b1; tick();
        hold_ack_n = 1'b0; tick();
        hold_ack_n = 1'b1; tick();
        hold_req_n = 1'b0; #1;
        chk("R8 masked after ack", hold_g, 1'b1);
        ext_req_n = 4'b0110; #1;
        chk("R5 ext masked in passive", ext_g, 4'hF);
        io_write(RADDR, 8'h00);
        idle_reqs();

        // R9: cancel the deferral, then re-set with passive release off
        passive_rel = 1'b1;
        io_write(RADDR, 8'h01);
        io_write(RADDR, 8'h00);
        hold_req_n = 1'b0; #1;
        chk("R9 no mask after cancel", hold_g, 1'b0);
        idle_reqs();
        passive_rel = 1'b0;
        hold_ack_n = 1'b1;
        io_write(RADDR, 8'h01);
        hold_req_n = 1'b0; #1;
        chk("R9 R6 masked on re-set", hold_g, 1'b1);
        io_write(RADDR, 8'h00);
        idle_reqs();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule